// File: doc/BRIEF.md
# Timer Event, Alarm and Trigger Capture Unit

This unit sits beside a free-running 64-bit time counter and turns time-related conditions into a single interrupt. It holds two 64-bit alarm values. Each alarm raises an event when the time input equals its programmed value. It also watches two external trigger pins, synchronizes them, and latches the time at the selected edge of each pin. It also takes strobes from a periodic-pulse generator that lives elsewhere.

All of these conditions land in one event register. Software clears its bits by writing ones. A mask register with the same bit layout selects which events drive the interrupt line. Two alarm pins follow their alarm event bits, and each pin's polarity is programmable. Software reaches everything through a simple 32-bit register bus with word addresses. Writes take effect at the clock edge and reads are combinational with no side effects. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and both `alarm_out` pins are 0.
- R2: Event bit positions are: trigger 2 capture at bit 25, trigger 1 capture at bit 24, alarm 2 at bit 17, alarm 1 at bit 16, pulse 1 at bit 7, pulse 2 at bit 6 and pulse 3 at bit 5. A high `pulse_stb[0]`, `[1]` or `[2]` sets the pulse 1, 2 or 3 bit at the next clock edge.
- R3: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged. When a source sets a bit in the same cycle that a write clears it, the set wins.
- R4: The mask register uses the event bit positions and stores only those seven bits, so writing all ones reads back 0x030300E0. `irq` is high exactly while some event bit and its mask bit are both 1.
- R5: Writing an alarm high word arms that alarm, and writing its low word disarms it. While an alarm is armed and `time_in` equals its full 64-bit value, its event bit is set at the next edge.
- R6: An alarm fires once per match and then stays disarmed until its high word is written again, even if the time keeps matching.
- R7: `alarm_out[0]` equals the alarm 1 event bit XOR control bit 31. `alarm_out[1]` equals the alarm 2 event bit XOR control bit 30.
- R8: Each trigger pin passes through a two-flop synchronizer and an edge detector. Control bit 8 selects the edge for trigger 1 and bit 9 selects it for trigger 2 (0 = rising, 1 = falling). On the selected edge the unit latches `time_in` and sets the trigger's event bit; the other edge has no effect. The capture is complete within five clocks of the pin change.
- R9: While a trigger's event bit is set, later edges on that pin leave its capture register unchanged.
- R10: Word addresses: 0 control (only bits 31, 30, 9 and 8 are stored), 1 event, 2 mask, 3/4 alarm 1 low/high, 5/6 alarm 2 low/high, 7/8 trigger 1 capture high/low, 9/10 trigger 2 capture high/low. Alarm registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| time_in | input | 64 | Current time from the counter |
| trig_in | input | 2 | External trigger pins (asynchronous) |
| pulse_stb | input | 3 | Periodic-pulse event strobes, one clock each |
| alarm_out | output | 2 | Alarm pins with programmable polarity |
| irq | output | 1 | Interrupt, high while a masked-in event is pending |

## Verification
The checks assume that `time_in` and the bus signals change only between clock edges. They also assume that trigger pins stay low while reset is held, so the synchronizer does not report a phantom edge at release. The stimulus drives every input on the falling clock edge and keeps trigger pins low through reset. It holds `time_in` constant across each trigger test, so the latched value does not depend on the exact synchronizer delay. Alarm matches are produced by stepping `time_in` to chosen values rather than by letting it count.

// File: rtl/tevt_pkg.sv
package tevt_pkg;
  localparam int DW     = 32;
  localparam int TW     = 64;
  localparam int AW     = 4;
  localparam int N_ALM  = 2;
  localparam int N_TRG  = 2;
  localparam int N_PLS  = 3;

  // word addresses
  localparam int A_CTRL   = 0;
  localparam int A_EVT    = 1;
  localparam int A_MASK   = 2;
  localparam int A_AL1_LO = 3;  // alarm i low at A_AL1_LO + 2*i, high one above
  localparam int A_CP1_HI = 7;  // capture i high at A_CP1_HI + 2*i, low one above

  // event bit positions
  localparam int B_TRG1 = 24;   // trigger i at B_TRG1 + i
  localparam int B_ALM1 = 16;   // alarm i at B_ALM1 + i
  localparam int B_PLS1 = 7;    // pulse i at B_PLS1 - i

  // control bit positions
  localparam int C_EDG1 = 8;    // trigger i edge select at C_EDG1 + i
  localparam int C_POL1 = 31;   // alarm i polarity at C_POL1 - i

  function automatic logic [DW-1:0] evt_impl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N_TRG; i++) m[B_TRG1 + i] = 1'b1;
    for (int i = 0; i < N_ALM; i++) m[B_ALM1 + i] = 1'b1;
    for (int i = 0; i < N_PLS; i++) m[B_PLS1 - i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] ctrl_impl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < N_TRG; i++) m[C_EDG1 + i] = 1'b1;
    for (int i = 0; i < N_ALM; i++) m[C_POL1 - i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] EVT_IMPL  = evt_impl_mask();
  localparam logic [DW-1:0] CTRL_IMPL = ctrl_impl_mask();
endpackage

// File: rtl/tevt_alarm.sv
module tevt_alarm #(
  parameter int DW = 32,
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] time_in,
  output logic [TW-1:0] val_q,
  output logic          armed_q,
  output logic          fire
);
  localparam int HW = TW - DW;

  logic [TW-1:0] val_d;
  logic          val_en;
  logic          arm_d;

  assign fire   = armed_q && (time_in == val_q);
  assign val_en = wr_lo || wr_hi;

  always_comb begin
    val_d = val_q;
    arm_d = armed_q;
    if (wr_lo) begin
      val_d[DW-1:0] = wdata;
      arm_d         = 1'b0;
    end else if (wr_hi) begin
      val_d[TW-1:DW] = wdata[HW-1:0];
      arm_d          = 1'b1;
    end else if (fire) begin
      arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (val_en) val_q <= val_d;
      armed_q <= arm_d;
    end
  end
endmodule

// File: rtl/tevt_trig.sv
module tevt_trig #(
  parameter int SYNC = 2,
  parameter int TW   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          fall_sel,
  input  logic          hold,
  input  logic [TW-1:0] time_in,
  output logic [TW-1:0] cap_q,
  output logic          hit
);
  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;
  logic            prev_q;
  logic            lvl;
  logic            edg;

  assign lvl    = sync_q[SYNC-1];
  assign sync_d = {sync_q[SYNC-2:0], pin};
  assign edg    = fall_sel ? (prev_q & ~lvl) : (~prev_q & lvl);
  assign hit    = edg & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (hit) cap_q <= time_in;
  end
endmodule

// File: rtl/tevt_evreg.sv
module tevt_evreg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] clr_eff;
  logic [W-1:0] evt_d;

  assign clr_eff = clr_en ? clr_vec : '0;

  always_comb begin
    evt_d = ((evt_q & ~clr_eff) | set_vec) & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tevt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [TW-1:0]        time_in,
  input  logic [N_TRG-1:0]     trig_in,
  input  logic [N_PLS-1:0]     pulse_stb,
  output logic [N_ALM-1:0]     alarm_out,
  output logic                 irq
);
  localparam int HW = TW - DW;

  // reset: asynchronous assert, synchronous release
  logic [RST_STAGES-1:0] rsync_q;
  logic                  rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rsync_q[RST_STAGES-1];

  // control and mask registers
  logic [DW-1:0] ctrl_q, mask_q;
  logic          ctrl_en, mask_en;
  logic [DW-1:0] ctrl_d, mask_d;

  assign ctrl_en = reg_wr && (reg_addr == AW'(A_CTRL));
  assign mask_en = reg_wr && (reg_addr == AW'(A_MASK));
  assign ctrl_d  = reg_wdata & CTRL_IMPL;
  assign mask_d  = reg_wdata & EVT_IMPL;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  // event register
  logic [DW-1:0] evt_q;
  logic [DW-1:0] set_vec;

  // alarms
  logic [TW-1:0]    alm_val [N_ALM];
  logic [N_ALM-1:0] alm_arm;
  logic [N_ALM-1:0] alm_fire;

  for (genvar g = 0; g < N_ALM; g++) begin : g_alm
    tevt_alarm #(.DW(DW), .TW(TW)) u_alm (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_lo   (reg_wr && (reg_addr == AW'(A_AL1_LO + 2*g))),
      .wr_hi   (reg_wr && (reg_addr == AW'(A_AL1_LO + 2*g + 1))),
      .wdata   (reg_wdata),
      .time_in (time_in),
      .val_q   (alm_val[g]),
      .armed_q (alm_arm[g]),
      .fire    (alm_fire[g])
    );
    assign alarm_out[g] = evt_q[B_ALM1 + g] ^ ctrl_q[C_POL1 - g];
  end

  // trigger capture
  logic [TW-1:0]    cap [N_TRG];
  logic [N_TRG-1:0] trg_hit;

  for (genvar g = 0; g < N_TRG; g++) begin : g_trg
    tevt_trig #(.SYNC(SYNC_STAGES), .TW(TW)) u_trg (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .pin      (trig_in[g]),
      .fall_sel (ctrl_q[C_EDG1 + g]),
      .hold     (evt_q[B_TRG1 + g]),
      .time_in  (time_in),
      .cap_q    (cap[g]),
      .hit      (trg_hit[g])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < N_ALM; i++) set_vec[B_ALM1 + i] = alm_fire[i];
    for (int i = 0; i < N_TRG; i++) set_vec[B_TRG1 + i] = trg_hit[i];
    for (int i = 0; i < N_PLS; i++) set_vec[B_PLS1 - i] = pulse_stb[i];
  end

  tevt_evreg #(.W(DW), .IMPL(EVT_IMPL)) u_evt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_vec (set_vec),
    .clr_en  (reg_wr && (reg_addr == AW'(A_EVT))),
    .clr_vec (reg_wdata),
    .evt_q   (evt_q)
  );

  assign irq = |(evt_q & mask_q);

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) reg_rdata = ctrl_q;
    if (reg_addr == AW'(A_EVT))  reg_rdata = evt_q;
    if (reg_addr == AW'(A_MASK)) reg_rdata = mask_q;
    for (int i = 0; i < N_ALM; i++) begin
      if (reg_addr == AW'(A_AL1_LO + 2*i))     reg_rdata = alm_val[i][DW-1:0];
      if (reg_addr == AW'(A_AL1_LO + 2*i + 1)) reg_rdata = DW'(alm_val[i][TW-1:DW]);
    end
    for (int i = 0; i < N_TRG; i++) begin
      if (reg_addr == AW'(A_CP1_HI + 2*i))     reg_rdata = DW'(cap[i][TW-1:TW-HW]);
      if (reg_addr == AW'(A_CP1_HI + 2*i + 1)) reg_rdata = cap[i][DW-1:0];
    end
  end
endmodule

// File: rtl/tevt_chk.sv
module tevt_chk
  import tevt_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [TW-1:0] time_in,
  input logic [DW-1:0] evt_q,
  input logic [DW-1:0] mask_q,
  input logic [1:0]    armed,
  input logic [TW-1:0] alm1_val,
  input logic [TW-1:0] alm2_val,
  input logic [TW-1:0] cap1,
  input logic [TW-1:0] cap2,
  input logic          irq
);
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((~evt_q & $past(evt_q)) != '0) |-> $past(reg_wr && reg_addr == AW'(A_EVT))); // R3

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0 && evt_q != '0)); // R4

  AST_ALM1_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[B_ALM1]) |-> $past(armed[0] && time_in == alm1_val)); // R5

  AST_ALM2_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q[B_ALM1 + 1]) |-> $past(armed[1] && time_in == alm2_val)); // R5

  AST_ALM1_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(evt_q[B_ALM1]) && !$past(reg_wr && reg_addr == AW'(A_AL1_LO + 1))) |-> !armed[0]); // R6

  AST_CAP1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_q[B_TRG1]) |-> $stable(cap1)); // R9

  AST_CAP2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt_q[B_TRG1 + 1]) |-> $stable(cap2)); // R9
endmodule

bind tmr_evt_unit tevt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .time_in  (time_in),
  .evt_q    (evt_q),
  .mask_q   (mask_q),
  .armed    (alm_arm),
  .alm1_val (alm_val[0]),
  .alm2_val (alm_val[1]),
  .cap1     (cap[0]),
  .cap2     (cap[1]),
  .irq      (irq)
);

// File: tb/sim_tmr_evt_unit.sv
module sim_tmr_evt_unit;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] time_in;
  logic [1:0]  trig_in;
  logic [2:0]  pulse_stb;
  logic [1:0]  alarm_out;
  logic        irq;

  tmr_evt_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .time_in   (time_in),
    .trig_in   (trig_in),
    .pulse_stb (pulse_stb),
    .alarm_out (alarm_out),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam int K_RD = 0, K_IRQ = 1, K_PIN = 2;
  localparam logic [3:0] RA_CTRL = 0, RA_EVT = 1, RA_MASK = 2,
                         RA_A1L = 3, RA_A1H = 4, RA_A2L = 5, RA_A2H = 6,
                         RA_C1H = 7, RA_C1L = 8, RA_C2H = 9, RA_C2L = 10;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  // monitor: pops expected items and compares one ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = (it.kind == K_RD)  ? reg_rdata :
              (it.kind == K_IRQ) ? {31'b0, irq} : {30'b0, alarm_out};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  // driver tasks: each acts at one falling edge
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      reg_wr = 1'b0; pulse_stb = '0;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; pulse_stb = '0;
  endtask

  task automatic wr_stb(input logic [3:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; pulse_stb = s;
  endtask

  task automatic strobe(input logic [2:0] s);
    @(negedge clk);
    reg_wr = 1'b0; pulse_stb = s;
  endtask

  task automatic set_time(input logic [63:0] t);
    @(negedge clk);
    reg_wr = 1'b0; pulse_stb = '0; time_in = t;
  endtask

  task automatic set_trig(input logic [1:0] v);
    @(negedge clk);
    reg_wr = 1'b0; pulse_stb = '0; trig_in = v;
  endtask

  task automatic expect_item(input int kind, input logic [3:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_wr = 1'b0; pulse_stb = '0; reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    expect_item(K_RD, a, e, tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  localparam logic [63:0] T1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] T2 = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] T3 = 64'h0000_0042_0000_0099;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    time_in = '0; trig_in = '0; pulse_stb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_rd(RA_CTRL, 32'h0, "R1 ctrl");
    chk_rd(RA_EVT,  32'h0, "R1 event");
    chk_rd(RA_MASK, 32'h0, "R1 mask");
    chk_rd(RA_A1H,  32'h0, "R1 alarm1 high");
    chk_rd(RA_C1L,  32'h0, "R1 capture1 low");
    expect_item(K_IRQ, RA_CTRL, 32'h0, "R1 irq");
    expect_item(K_PIN, RA_CTRL, 32'h0, "R1 alarm pins");

    // R4 mask layout, R10 control layout
    wr(RA_MASK, 32'hFFFF_FFFF);
    chk_rd(RA_MASK, 32'h0303_00E0, "R4 mask bits");
    wr(RA_CTRL, 32'hFFFF_FFFF);
    chk_rd(RA_CTRL, 32'hC000_0300, "R10 ctrl bits");
    wr(RA_CTRL, 32'h0);
    wr(RA_MASK, 32'h0);

    // R2 pulse strobes
    strobe(3'b001);
    chk_rd(RA_EVT, 32'h0000_0080, "R2 pulse1 bit7");
    strobe(3'b010);
    strobe(3'b100);
    chk_rd(RA_EVT, 32'h0000_00E0, "R2 pulses bits7-5");

    // R3 write-one-to-clear, set wins
    wr(RA_EVT, 32'h0000_0040);
    chk_rd(RA_EVT, 32'h0000_00A0, "R3 w1c partial");
    wr_stb(RA_EVT, 32'h0000_0080, 3'b001);
    chk_rd(RA_EVT, 32'h0000_00A0, "R3 set beats clear");
    wr(RA_EVT, 32'hFFFF_FFFF);
    chk_rd(RA_EVT, 32'h0, "R3 clear all");

    // R4 interrupt
    strobe(3'b100);
    expect_item(K_IRQ, RA_EVT, 32'h0, "R4 irq masked off");
    wr(RA_MASK, 32'h0000_0020);
    expect_item(K_IRQ, RA_EVT, 32'h1, "R4 irq enabled");
    wr(RA_MASK, 32'h0000_0040);
    expect_item(K_IRQ, RA_EVT, 32'h0, "R4 irq other mask");
    wr(RA_EVT, 32'h0000_0020);
    wr(RA_MASK, 32'h0);

    // R5 alarm 1
    set_time(64'd0);
    wr(RA_A1L, 32'd5);
    wr(RA_A1H, 32'd0);
    chk_rd(RA_A1L, 32'd5, "R10 alarm1 low readback");
    set_time(64'd4);
    chk_rd(RA_EVT, 32'h0, "R5 no match");
    set_time(64'd5);
    chk_rd(RA_EVT, 32'h0001_0000, "R5 alarm1 match");
    set_time(64'd6);
    // R7 pin polarity
    expect_item(K_PIN, RA_EVT, 32'h1, "R7 alarm1 pin high");
    wr(RA_CTRL, 32'h8000_0000);
    expect_item(K_PIN, RA_EVT, 32'h0, "R7 alarm1 pin inverted");
    wr(RA_CTRL, 32'h0);

    // R6 fires once
    wr(RA_EVT, 32'h0001_0000);
    set_time(64'd5);
    idle(3);
    chk_rd(RA_EVT, 32'h0, "R6 no refire");
    wr(RA_A1H, 32'd0);
    idle(1);
    chk_rd(RA_EVT, 32'h0001_0000, "R6 rearm by high write");
    wr(RA_EVT, 32'h0001_0000);
    set_time(64'd0);
    wr(RA_A1H, 32'd0);
    wr(RA_A1L, 32'd5);
    set_time(64'd5);
    idle(2);
    chk_rd(RA_EVT, 32'h0, "R5 low write disarms");

    // R5 full 64-bit compare on alarm 2
    wr(RA_A2L, 32'h0000_0064);
    wr(RA_A2H, 32'h0000_0001);
    chk_rd(RA_A2H, 32'h1, "R10 alarm2 high readback");
    set_time(64'h0000_0000_0000_0064);
    idle(1);
    chk_rd(RA_EVT, 32'h0, "R5 high word differs");
    set_time(64'h0000_0001_0000_0064);
    chk_rd(RA_EVT, 32'h0002_0000, "R5 alarm2 match");
    expect_item(K_PIN, RA_EVT, 32'h2, "R7 alarm2 pin");
    wr(RA_CTRL, 32'h4000_0000);
    expect_item(K_PIN, RA_EVT, 32'h0, "R7 alarm2 pin inverted");
    wr(RA_CTRL, 32'h0);
    wr(RA_EVT, 32'h0002_0000);

    // R8 trigger 1 rising capture
    set_time(T1);
    set_trig(2'b01);
    idle(5);
    chk_rd(RA_EVT, 32'h0100_0000, "R8 trigger1 event");
    chk_rd(RA_C1H, T1[63:32], "R8 capture1 high");
    chk_rd(RA_C1L, T1[31:0], "R8 capture1 low");

    // R9 hold while pending
    set_time(T2);
    set_trig(2'b00);
    idle(4);
    set_trig(2'b01);
    idle(5);
    chk_rd(RA_C1L, T1[31:0], "R9 capture1 held");

    // R8 opposite edge ignored, then new capture
    wr(RA_EVT, 32'h0100_0000);
    set_trig(2'b00);
    idle(5);
    chk_rd(RA_EVT, 32'h0, "R8 falling edge ignored");
    set_trig(2'b01);
    idle(5);
    chk_rd(RA_C1L, T2[31:0], "R8 recapture low");
    chk_rd(RA_C1H, T2[63:32], "R8 recapture high");

    // R8 trigger 2 falling-edge mode
    wr(RA_CTRL, 32'h0000_0200);
    set_trig(2'b11);
    idle(5);
    chk_rd(RA_EVT, 32'h0100_0000, "R8 trigger2 rise ignored");
    set_time(T3);
    set_trig(2'b01);
    idle(5);
    chk_rd(RA_EVT, 32'h0300_0000, "R8 trigger2 falling event");
    chk_rd(RA_C2H, T3[63:32], "R8 capture2 high");
    chk_rd(RA_C2L, T3[31:0], "R8 capture2 low");

    idle(3);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule